// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit forms the memory address for one load or store, together with the value that may be written back to the base register. It takes an already decoded request: a base value, an offset, the way the offset is prepared, an add/subtract choice and an indexing mode. On a valid strobe it registers the memory address, the writeback value and a writeback-enable flag, and presents them one cycle later.

The offset is either a short immediate or the value of a second register. A register offset passes through a barrel shifter first. The shifter supports logical left, logical right, arithmetic right, rotate right, and a one-position rotate that brings the carry flag into the top bit. Three indexing modes decide whether the address uses the adjusted base or the plain base, and whether the base register is updated.

Top module: `ls_addr_gen`

## Requirements
- R1: With `idx_mode` 0 (plain offset), or the unused code 3, `mem_addr` is `base_val` plus or minus the offset, `wb_val` equals `base_val`, and `wb_en` is 0.
- R2: With `idx_mode` 1 (update before access), `mem_addr` is `base_val` plus or minus the offset, `wb_val` equals that same address, and `wb_en` is 1.
- R3: With `idx_mode` 2 (update after access), `mem_addr` equals `base_val`, `wb_val` is `base_val` plus or minus the offset, and `wb_en` is 1.
- R4: With `off_is_reg` 0, the offset is the 12-bit `imm_off` zero-extended to 32 bits. `reg_off`, `sh_kind`, `sh_amt` and `carry_in` have no effect on it.
- R5: `off_sub` 1 subtracts the offset from the base and 0 adds it, both modulo 2^32.
- R6: With `off_is_reg` 1 and `sh_kind` 0, the offset is `reg_off` shifted left by `sh_amt` (0 to 31) with zero fill. `sh_kind` codes 5 to 7 pass `reg_off` through unchanged.
- R7: `sh_kind` 1 shifts `reg_off` right by `sh_amt`, filling with zeros.
- R8: `sh_kind` 2 shifts `reg_off` right by `sh_amt`, filling with copies of bit 31.
- R9: `sh_kind` 3 rotates `reg_off` right by `sh_amt`. Bits leaving bit 0 re-enter at bit 31.
- R10: `sh_kind` 4 rotates right by exactly one through the carry. The offset is {`carry_in`, `reg_off`[31:1]}, and `sh_amt` is ignored.
- R11: Outputs change one cycle after a cycle with `in_valid` high. `out_valid` is high exactly in the cycle after each `in_valid` cycle.
- R12: In the cycle after a cycle with `in_valid` low, `out_valid` is 0 and `mem_addr`, `wb_val` and `wb_en` keep their previous values, whatever the other inputs do.
- R13: While `rst_n` is low, all outputs are 0. Release of reset takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset |
| reg_off | input | 32 | Offset register value |
| off_is_reg | input | 1 | 1: register offset, 0: immediate |
| sh_kind | input | 3 | Shift operation code for the register offset |
| sh_amt | input | 5 | Immediate shift amount |
| carry_in | input | 1 | Carry flag for the rotate through carry |
| off_sub | input | 1 | 1: subtract offset, 0: add |
| idx_mode | input | 2 | Indexing mode |
| out_valid | output | 1 | Result strobe |
| mem_addr | output | 32 | Memory address |
| wb_val | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register writeback enable |

## Verification
The bench sweeps all four mode codes, all eight shift codes, every shift amount from 0 to 31, both add and subtract, and both offset sources. Base, register and immediate values are pseudo-random for each combination. Sweeping every shift amount separates the fill rules of the left, logical-right and arithmetic-right shifts, and the wrap of the rotate. Random carries and random amounts show that the carry rotate uses the carry and ignores the amount. Comparing each mode against the same sum tells apart which output carries the adjusted base and which carries the plain base. An idle cycle with scrambled inputs after every request confirms that the outputs hold.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_e;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2
  } idx_e;

endpackage

// File: rtl/ls_addr_rst_sync.sv
module ls_addr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ls_addr_shifter.sv
module ls_addr_shifter
  import ls_addr_pkg::*;
#(
  parameter  int DW  = 32,
  localparam int SHW = $clog2(DW)
) (
  input  logic [2:0]     kind,
  input  logic [SHW-1:0] amt,
  input  logic           carry_in,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout
);

  logic [2*DW-1:0] rot_wide;
  logic [DW-1:0]   asr_res;

  always_comb begin
    rot_wide = {din, din} >> amt;
    asr_res  = $unsigned($signed(din) >>> amt);
    case (kind)
      SH_LSL:  dout = din << amt;
      SH_LSR:  dout = din >> amt;
      SH_ASR:  dout = asr_res;
      SH_ROR:  dout = rot_wide[DW-1:0];
      SH_RRX:  dout = {carry_in, din[DW-1:1]};
      default: dout = din;
    endcase
  end

  always_comb begin
    if (kind == SH_LSL && amt == '0)
      p_lsl_zero_amt_r6: assert (dout == din);
    if (kind == SH_LSR && amt != '0)
      p_lsr_zero_fill_r7: assert (dout[DW-1] == 1'b0);
    if (kind == SH_ASR)
      p_asr_sign_keep_r8: assert (dout[DW-1] == din[DW-1]);
    if (kind == SH_ROR)
      p_ror_popcount_r9: assert ($countones(dout) == $countones(din));
    if (kind == SH_RRX)
      p_rrx_carry_top_r10: assert (dout[DW-1] == carry_in);
  end

endmodule

// File: rtl/ls_addr_addsub.sv
module ls_addr_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum
);

  logic [DW-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(DW-1){1'b0}}, sub};
  end

  logic [DW-1:0] undo;
  always_comb begin
    undo = sub ? (sum + b) : (sum - b);
    p_addsub_inverse_r5: assert (undo == a);
  end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_pkg::*;
#(
  parameter  int DW   = 32,
  parameter  int IMMW = 12,
  localparam int SHW  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   base_val,
  input  logic [IMMW-1:0] imm_off,
  input  logic [DW-1:0]   reg_off,
  input  logic            off_is_reg,
  input  logic [2:0]      sh_kind,
  input  logic [SHW-1:0]  sh_amt,
  input  logic            carry_in,
  input  logic            off_sub,
  input  logic [1:0]      idx_mode,
  output logic            out_valid,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   wb_val,
  output logic            wb_en
);

  logic rst_sync_n;

  ls_addr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [DW-1:0] shifted;
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] offset;
  logic [DW-1:0] adj_base;

  ls_addr_shifter #(.DW(DW)) u_shift (
    .kind     (sh_kind),
    .amt      (sh_amt),
    .carry_in (carry_in),
    .din      (reg_off),
    .dout     (shifted)
  );

  always_comb begin
    imm_ext = {{(DW-IMMW){1'b0}}, imm_off};
    offset  = off_is_reg ? shifted : imm_ext;
  end

  ls_addr_addsub #(.DW(DW)) u_add (
    .a   (base_val),
    .b   (offset),
    .sub (off_sub),
    .sum (adj_base)
  );

  logic [DW-1:0] addr_d, wbv_d;
  logic          wben_d;
  logic [DW-1:0] addr_q, wbv_q;
  logic          wben_q, vld_q;

  always_comb begin
    case (idx_mode)
      IDX_PRE: begin
        addr_d = adj_base;
        wbv_d  = adj_base;
        wben_d = 1'b1;
      end
      IDX_POST: begin
        addr_d = base_val;
        wbv_d  = adj_base;
        wben_d = 1'b1;
      end
      default: begin
        addr_d = adj_base;
        wbv_d  = base_val;
        wben_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      wbv_q  <= '0;
      wben_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        addr_q <= addr_d;
        wbv_q  <= wbv_d;
        wben_q <= wben_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign mem_addr  = addr_q;
  assign wb_val    = wbv_q;
  assign wb_en     = wben_q;

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_idle_no_valid_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(mem_addr) && $stable(wb_val) && $stable(wb_en)));
  p_post_plain_addr_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && idx_mode == IDX_POST) |=> (mem_addr == $past(base_val) && wb_en));
  p_pre_same_value_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && idx_mode == IDX_PRE) |=> (wb_val == mem_addr && wb_en));
  p_offset_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (idx_mode == IDX_OFFSET || idx_mode == 2'd3)) |=>
      (!wb_en && wb_val == $past(base_val)));

  always_comb begin
    if (!rst_n)
      p_reset_clear_r13: assert (!out_valid && !wb_en);
  end

endmodule

// File: tb/tb_ls_addr_gen.sv
module tb_ls_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WATCHDOG = 100000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [DW-1:0]   base_val;
  logic [11:0]     imm_off;
  logic [DW-1:0]   reg_off;
  logic            off_is_reg;
  logic [2:0]      sh_kind;
  logic [4:0]      sh_amt;
  logic            carry_in;
  logic            off_sub;
  logic [1:0]      idx_mode;
  logic            out_valid;
  logic [DW-1:0]   mem_addr;
  logic [DW-1:0]   wb_val;
  logic            wb_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .imm_off(imm_off), .reg_off(reg_off), .off_is_reg(off_is_reg),
    .sh_kind(sh_kind), .sh_amt(sh_amt), .carry_in(carry_in),
    .off_sub(off_sub), .idx_mode(idx_mode), .out_valid(out_valid),
    .mem_addr(mem_addr), .wb_val(wb_val), .wb_en(wb_en)
  );

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed ^ (seed >> 13);
  endfunction

  function automatic logic [31:0] model_shift(int kind, int amt, logic c, logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (kind)
        0: r[i] = (i >= amt) ? x[i-amt] : 1'b0;
        1: r[i] = (i + amt < 32) ? x[i+amt] : 1'b0;
        2: r[i] = (i + amt < 32) ? x[i+amt] : x[31];
        3: r[i] = x[(i+amt)%32];
        4: begin
          if (i == 31) r[i] = c;
          else         r[i] = x[i+1];
        end
        default: r[i] = x[i];
      endcase
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic scramble();
    base_val   = next_rand();
    reg_off    = next_rand();
    imm_off    = next_rand() & 32'hFFF;
    carry_in   = next_rand() & 1;
    sh_kind    = next_rand() & 7;
    sh_amt     = next_rand() & 31;
    off_sub    = next_rand() & 1;
    off_is_reg = next_rand() & 1;
    idx_mode   = next_rand() & 3;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    scramble();
    repeat (3) @(negedge clk);
    // R13: outputs cleared in reset, even with a request present
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R13 out_valid", 32'(out_valid), 0);
    check(mem_addr == '0, "R13 mem_addr", mem_addr, 0);
    check(wb_val == '0, "R13 wb_val", wb_val, 0);
    check(wb_en == 1'b0, "R13 wb_en", 32'(wb_en), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        for (int a = 0; a < 32; a++)
          for (int s = 0; s < 2; s++)
            for (int r = 0; r < 2; r++) begin
              logic [31:0] off, adj, e_addr, e_wbv, p_addr, p_wbv;
              logic e_wben, p_wben;
              string mtag, stag, tag;
              base_val   = next_rand();
              reg_off    = next_rand();
              imm_off    = next_rand() & 32'hFFF;
              carry_in   = next_rand() & 1;
              idx_mode   = 2'(m);
              sh_kind    = 3'(k);
              sh_amt     = 5'(a);
              off_sub    = s[0];
              off_is_reg = r[0];
              in_valid   = 1'b1;
              off = r ? model_shift(k, a, carry_in, reg_off) : {20'd0, imm_off};
              adj = s ? base_val - off : base_val + off;
              case (m)
                1: begin e_addr = adj; e_wbv = adj; e_wben = 1'b1; mtag = "R2"; end
                2: begin e_addr = base_val; e_wbv = adj; e_wben = 1'b1; mtag = "R3"; end
                default: begin e_addr = adj; e_wbv = base_val; e_wben = 1'b0; mtag = "R1"; end
              endcase
              if (!r) stag = "R4";
              else case (k)
                1: stag = "R7";
                2: stag = "R8";
                3: stag = "R9";
                4: stag = "R10";
                default: stag = "R6";
              endcase
              tag = $sformatf("%s/%s/R5 m=%0d k=%0d a=%0d s=%0d r=%0d", mtag, stag, m, k, a, s, r);
              @(negedge clk);
              check(out_valid == 1'b1, "R11 out_valid", 32'(out_valid), 1);
              check(mem_addr == e_addr, {"mem_addr ", tag}, mem_addr, e_addr);
              check(wb_val == e_wbv, {"wb_val ", tag}, wb_val, e_wbv);
              check(wb_en == e_wben, {"wb_en ", tag}, 32'(wb_en), 32'(e_wben));
              p_addr = mem_addr; p_wbv = wb_val; p_wben = wb_en;
              // R12: idle cycle with scrambled inputs must not disturb outputs
              in_valid = 1'b0;
              scramble();
              @(negedge clk);
              check(out_valid == 1'b0, "R12 out_valid", 32'(out_valid), 0);
              check(mem_addr == p_addr, "R12 mem_addr hold", mem_addr, p_addr);
              check(wb_val == p_wbv, "R12 wb_val hold", wb_val, p_wbv);
              check(wb_en == p_wben, "R12 wb_en hold", 32'(wb_en), 32'(p_wben));
            end

    finish_run();
  end

endmodule